// File: doc/BRIEF.md
# Fractional-Period Timemark Slewing Unit

This block refines a coarse periodic tick to single fast-clock resolution. It sits between a coarse tick generator and a one-pulse-per-second timemark output. Every coarse tick adds a programmable 3-bit correction to a modulo-7 phase accumulator.

When an addition reaches 7 or more, the accumulator wraps. The block then asks the coarse counter to lengthen the following tick period by holding its stretch request for that period. It also raises a sticky interrupt and a sticky adjust flag. When a raw timemark arrives in the same cycle as a tick, the freshly updated phase is captured. The timemark then travels through a 7-stage delay chain and leaves that many fast-clock cycles (25 ns each at 40 MHz) late. The chain runs on the falling clock edge, so every output pulse also carries half a cycle of retiming delay.

Software configures the block and reads its state through a small register port. The read path is combinational and a write takes effect at the next rising edge.

Top module: `tm_slew_top`

## Requirements
- R1: After the asynchronous reset, the phase, correction, enable field, stretch request, adjust flag, interrupt and timemark output are all zero.
- R2: In a cycle with `tick_i` high, the phase becomes (phase + correction) mod 7 at the next rising edge. Without a tick the phase holds.
- R3: An overflow is a tick whose sum phase + correction is 7 or more. A correction of 7 therefore always overflows and leaves the phase unchanged.
- R4: Enable bit 0 (config bit 3) gates the stretch request. `stretch_o` takes the value "overflow and enable bit 0" at each tick and holds it until the next tick.
- R5: Enable bit 1 (config bit 4) gates the interrupt. An enabled overflow sets `irq_o`, and it stays set until a write to address 1 with data bit 4 set. If a clear and an enabled overflow fall in the same cycle, the interrupt stays set.
- R6: The adjust flag (status bit 3) is set by an overflow when enable bit 0 is set. Writing address 1 with data bit 3 set clears it, and a coincident overflow wins.
- R7: With the enable field at 00, overflows produce no stretch, no interrupt and no adjust flag. The phase still accumulates and the delay path still works.
- R8: Address 0 reads and writes the config register: bits 2:0 hold the correction and bits 4:3 the enable field. Address 1 reads the status register: bits 2:0 phase, bit 3 adjust flag, bit 4 interrupt. Writes to status bits 2:0 are ignored.
- R9: A `raw_tm_i` pulse in a tick cycle k produces a single one-cycle `tm_o` pulse. The pulse rises at the falling edge of cycle k+N, where N is the phase value that tick produces. A raw timemark outside a tick cycle is ignored.
- R10: When the correction is 0 and the phase is 0, N is 0 and `tm_o` follows the raw timemark by only the half-cycle retiming delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (40 MHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Coarse tick strobe, one cycle wide |
| raw_tm_i | input | 1 | Raw timemark, only valid together with a tick |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address (0 config, 1 status) |
| wdata_i | input | 5 | Register write data |
| rdata_o | output | 5 | Register read data for `addr_i` |
| stretch_o | output | 1 | Request to stretch the next coarse tick period |
| irq_o | output | 1 | Sticky overflow interrupt |
| tm_o | output | 1 | Delayed timemark |

## Verification
The bench steps the correction through every value from 0 to 7, including 7, which must overflow on every tick without moving the phase. A design that compared with "greater than" would miss the case where the sum is exactly 7. Clears are issued in the same cycle as an enabled overflow, where a design that gave the clear priority would drop the interrupt or the adjust flag. Raw timemarks are sent with every delay value from 0 to 6 and also outside tick cycles. A design that captured the stale phase, or mis-tapped the chain, would move the `tm_o` pulse to the wrong cycle. The enable field is swept through 00, 01, 10 and 11 to show that each bit gates only its own outputs.

// File: rtl/tm_slew_pkg.sv
`timescale 1ns/1ps
package tm_slew_pkg;
  localparam int PHASE_MOD = 7;
  localparam int PH_W      = $clog2(PHASE_MOD);
  localparam int CORR_W    = 3;
  localparam int EN_W      = 2;
  localparam int DATA_W    = CORR_W + EN_W;
  localparam int SUM_W     = ((PH_W > CORR_W) ? PH_W : CORR_W) + 1;

  typedef enum logic {
    ADDR_CFG  = 1'b0,
    ADDR_STAT = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic [EN_W-1:0]   en;
    logic [CORR_W-1:0] corr;
  } cfg_t;

  localparam int EN_STRETCH = 0;
  localparam int EN_IRQ     = 1;
  localparam int STAT_ADJ   = PH_W;
  localparam int STAT_IRQ   = PH_W + 1;
endpackage

// File: rtl/tm_phase_acc.sv
`timescale 1ns/1ps
module tm_phase_acc
  import tm_slew_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CORR_W-1:0] corr_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [PH_W-1:0]   phase_nxt_o,
  output logic              ovf_o
);
  logic [PH_W-1:0]  phase_q;
  logic [SUM_W-1:0] sum;
  logic             wrap;

  always_comb begin
    sum  = SUM_W'(phase_q) + SUM_W'(corr_i);
    wrap = (sum >= SUM_W'(PHASE_MOD));
    if (wrap) phase_nxt_o = PH_W'(sum - SUM_W'(PHASE_MOD));
    else      phase_nxt_o = PH_W'(sum);
  end

  assign ovf_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_i) phase_q <= phase_nxt_o;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tm_ctrl_regs.sv
`timescale 1ns/1ps
module tm_ctrl_regs
  import tm_slew_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              ovf_i,
  input  logic [PH_W-1:0]   phase_i,
  output cfg_t              cfg_o,
  output logic              stretch_o,
  output logic              adj_o,
  output logic              irq_o,
  output logic              clr_adj_o,
  output logic              clr_irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  cfg_t cfg_q;
  logic stretch_q, adj_q, irq_q;
  logic wr_cfg, wr_stat, set_adj, set_irq;

  assign wr_cfg    = we_i & (reg_addr_e'(addr_i) == ADDR_CFG);
  assign wr_stat   = we_i & (reg_addr_e'(addr_i) == ADDR_STAT);
  assign clr_adj_o = wr_stat & wdata_i[STAT_ADJ];
  assign clr_irq_o = wr_stat & wdata_i[STAT_IRQ];
  assign set_adj   = ovf_i & cfg_q.en[EN_STRETCH];
  assign set_irq   = ovf_i & cfg_q.en[EN_IRQ];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (wr_cfg) cfg_q <= cfg_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stretch_q <= 1'b0;
    else if (tick_i) stretch_q <= set_adj;
  end

  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (set_adj)        adj_q <= 1'b1;
      else if (clr_adj_o) adj_q <= 1'b0;
      if (set_irq)        irq_q <= 1'b1;
      else if (clr_irq_o) irq_q <= 1'b0;
    end
  end

  always_comb begin
    if (reg_addr_e'(addr_i) == ADDR_CFG) rdata_o = cfg_q;
    else                                 rdata_o = {irq_q, adj_q, phase_i};
  end

  assign cfg_o     = cfg_q;
  assign stretch_o = stretch_q;
  assign adj_o     = adj_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/tm_delay_line.sv
`timescale 1ns/1ps
module tm_delay_line
  import tm_slew_pkg::*;
#(
  parameter int STAGES = PHASE_MOD
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic [PH_W-1:0] sel_i,
  output logic            tm_o
);
  localparam int SEL_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [STAGES-1:0] stage_q;
  logic [PH_W-1:0]   sel_q;

  // whole delay path retimed on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (launch_i) sel_q <= sel_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= launch_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign tm_o = stage_q[SEL_W'(sel_q)];
endmodule

// File: rtl/tm_slew_top.sv
`timescale 1ns/1ps
module tm_slew_top
  import tm_slew_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              raw_tm_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stretch_o,
  output logic              irq_o,
  output logic              tm_o
);
  cfg_t            cfg;
  logic [PH_W-1:0] phase, phase_nxt;
  logic            ovf, adj, clr_adj, clr_irq, launch;

  tm_phase_acc i_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .corr_i     (cfg.corr),
    .phase_o    (phase),
    .phase_nxt_o(phase_nxt),
    .ovf_o      (ovf)
  );

  tm_ctrl_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .tick_i   (tick_i),
    .ovf_i    (ovf),
    .phase_i  (phase),
    .cfg_o    (cfg),
    .stretch_o(stretch_o),
    .adj_o    (adj),
    .irq_o    (irq_o),
    .clr_adj_o(clr_adj),
    .clr_irq_o(clr_irq),
    .rdata_o  (rdata_o)
  );

  assign launch = tick_i & raw_tm_i;

  tm_delay_line #(.STAGES(PHASE_MOD)) i_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .sel_i   (phase_nxt),
    .tm_o    (tm_o)
  );
endmodule

// File: rtl/tm_slew_chk.sv
`timescale 1ns/1ps
module tm_slew_chk
  import tm_slew_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [CORR_W-1:0] corr,
  input logic [EN_W-1:0]   en,
  input logic [PH_W-1:0]   phase,
  input logic              stretch,
  input logic              adj,
  input logic              irq,
  input logic              clr_irq
);
  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase) < PHASE_MOD);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> int'(phase) == (int'($past(phase)) + int'($past(corr))) % PHASE_MOD);

  a_r4_stretch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(stretch));

  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq && !clr_irq |=> irq);

  a_r5_irq_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && en[EN_IRQ] && (int'(phase) + int'(corr) >= PHASE_MOD) |=> irq);

  a_r7_no_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !en[EN_STRETCH] |=> !stretch);

  a_r6_adj_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && en[EN_STRETCH] && (int'(phase) + int'(corr) >= PHASE_MOD) |=> adj);
endmodule

bind tm_slew_top tm_slew_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .corr   (cfg.corr),
  .en     (cfg.en),
  .phase  (phase),
  .stretch(stretch_o),
  .adj    (adj),
  .irq    (irq_o),
  .clr_irq(clr_irq)
);

// File: tb/test_tm_slew_top.sv
`timescale 1ns/1ps
module test_tm_slew_top;
  localparam int CLK_PERIOD = 10;
  localparam int MOD = 7;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       tick = 1'b0, raw = 1'b0, we = 1'b0, addr = 1'b0;
  logic [4:0] wdata = '0;
  logic [4:0] rdata;
  logic       stretch, irq, tm;

  int checks = 0, errors = 0, cyc = 0;
  int m_ph = 0, m_corr = 0, m_en = 0, due = -100;
  bit m_str = 0, m_adj = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tm_slew_top i_tm_slew_top (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .raw_tm_i(raw),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .stretch_o(stretch), .irq_o(irq), .tm_o(tm)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // drive one cycle, check just before the next rising edge, then advance the model
  task automatic step(input bit t, input bit r, input bit w, input bit a, input int d);
    int sum, nph, exp_rd;
    bit ov;
    tick = t; raw = r; we = w; addr = a; wdata = 5'(d);
    #(CLK_PERIOD - 2);
    sum = m_ph + m_corr;
    ov  = (sum >= MOD);
    nph = sum % MOD;
    if (t && r) due = cyc + nph;                          // R9
    exp_rd = a ? ((int'(m_irq) << 4) | (int'(m_adj) << 3) | m_ph)
               : ((m_en << 3) | m_corr);
    chk("R8 rdata", int'(rdata), exp_rd);
    chk("R4 stretch", int'(stretch), int'(m_str));
    chk("R5 irq", int'(irq), int'(m_irq));
    chk("R9 tm", int'(tm), int'(cyc == due));
    if (w && !a) begin m_corr = d & 7; m_en = (d >> 3) & 3; end
    if (w && a && d[3]) m_adj = 0;
    if (w && a && d[4]) m_irq = 0;
    if (t) begin
      m_ph  = nph;
      m_str = ov && m_en[0];
      if (ov && m_en[0]) m_adj = 1;                        // R6 set wins
      if (ov && m_en[1]) m_irq = 1;                        // R5 set wins
    end
    @(posedge clk); #1;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, i[0], 0);
  endtask

  task automatic tick_run(input int n, input bit r);
    for (int i = 0; i < n; i++) begin
      step(1, r, 0, 1, 0);
      idle(9);
    end
  endtask

  task automatic wcfg(input int corr, input int en);
    step(0, 0, 1, 0, (en << 3) | corr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2;
    // R1: reset state
    chk("R1 stretch", int'(stretch), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 tm", int'(tm), 0);
    chk("R1 cfg", int'(rdata), 0);
    @(posedge clk); @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    idle(3);
    // R10: zero correction, zero delay
    tick_run(2, 1);
    // R7: enable field 00, accumulation and delay still active
    wcfg(3, 0);
    tick_run(6, 1);
    // R2/R3/R4/R6: every correction value with stretch only
    for (int c = 0; c < 8; c++) begin
      wcfg(c, 1);
      tick_run(4, 1);
    end
    // R5: interrupt only, then both
    wcfg(5, 2);
    tick_run(3, 1);
    step(0, 0, 1, 1, 5'h18);                               // clear both flags
    wcfg(7, 3);
    tick_run(2, 0);
    // R5/R6: clear coincident with an overflow tick keeps flags set
    step(1, 1, 1, 1, 5'h18);
    idle(9);
    step(0, 0, 1, 1, 5'h18);
    // R8: writes to phase bits ignored
    step(0, 0, 1, 1, 5'h07);
    idle(2);
    // R9: raw timemark without a tick is ignored
    wcfg(4, 3);
    step(0, 1, 0, 1, 0);
    idle(9);
    for (int k = 0; k < 7; k++) tick_run(1, 1);
    // raw off every other tick
    wcfg(6, 1);
    for (int k = 0; k < 6; k++) tick_run(1, k[0]);
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule